// File: doc/BRIEF.md
# Byte-Coded Multi-Cycle CPU Core

This block is a small 8-bit processor core with eight 8-bit registers, a 16-bit program counter and two condition flags: zero (Z) and carry (C). It runs one instruction at a time from a single byte-wide memory port. Each opcode is one byte. Some opcodes are followed by an immediate byte or by a two-byte absolute address. The instruction set covers absolute and register-indirect jumps, loads and stores through a pair of registers used as a pointer, direct loads and stores, immediate moves, single-register arithmetic, and two-register arithmetic, logic, copy and swap. An undefined opcode stops the core and raises a halt output.

The memory port is a plain synchronous port with a fixed latency: the read data for an address presented in one cycle is valid in the next cycle, and a write happens at the clock edge while the write strobe is high. The port has no valid/ready handshake. The memory must accept a request in every cycle, because the core never waits. After reset the core starts fetching at 0200h. A typical use is a small program loop, such as a zero-terminated byte copy.

Top module: `byte_cpu_core`

## Requirements
- R1: After reset the core has PC 0200h, all eight registers at 00h, Z and C clear, and the halt output low, and it presents address 0200h for the first fetch.
- R2: Read data is consumed one cycle after its address is presented. Operand bytes follow the opcode at consecutive addresses, and an absolute address is given low byte first. The write of a direct store is driven in the third cycle after the opcode address.
- R3: Opcode 70h jumps to an absolute address. Opcode 71h jumps only when Z is set, and 72h only when C is set. Opcode 73h jumps to the address formed by R1 (high byte) and R0 (low byte).
- R4: Opcode 0111_10pp stores R0 and opcode 0111_11pp loads R0, in both cases through a pointer. The pointer uses Rp as its low byte and Rp+1 as its high byte, with p from 0 to 3.
- R5: Opcode 0100_0rrr stores Rr to an absolute address. Opcode 0100_1rrr loads Rr from an absolute address.
- R6: Opcode 0101_0rrr loads the following byte into Rr.
- R7: Opcode 0110_0rrr increments Rr, 0101_1rrr decrements Rr and 0110_1rrr inverts Rr. All three set Z from the result. Increment sets C on a wrap from FFh, and decrement sets C on a borrow from 00h. Invert leaves C unchanged.
- R8: Opcode 1ffddsss applies a two-register operation with destination Rdd (R0 to R3) and source Rsss. For ff=00 it adds, setting C on a carry out. For ff=01 it subtracts, setting C on a borrow. For ff=10 it does a bitwise AND and leaves C unchanged. All three set Z from the result.
- R9: Opcode 111ddsss swaps Rdd and Rsss. Opcode 00dddsss copies Rsss into Rddd.
- R10: Loads, stores, immediate moves, register copies, swaps and jumps leave Z and C unchanged.
- R11: Opcodes 74h to 77h raise the halt output two clock edges after their fetch address. The core then stays halted until reset and never writes memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | 16 | Memory address for read or write |
| mem_wdata_o | output | 8 | Write data |
| mem_we_o | output | 1 | Write strobe, taken at the clock edge |
| mem_rdata_i | input | 8 | Read data for the address of the previous cycle |
| halt_o | output | 1 | High once an undefined opcode has been fetched |

## Verification
Two events share a single clock edge in this core. A swap writes both register-file ports at once. An arithmetic operation writes its destination register and the flags together. The swap is provoked by exchanging two preloaded registers and storing both back: both stored bytes must show the exchange, and a copy made right afterwards must see the new value. The flag case is provoked by following each arithmetic operation with a store of the result and with Z- and C-conditional jumps that each leave a marker byte. The stored result and both markers are then compared with values worked out by hand.

// File: rtl/bcpu_pkg.sv
package bcpu_pkg;

  localparam int REG_CNT = 8;
  localparam int SEL_W   = 3;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_OPLO, ST_OPHI, ST_IMM, ST_LOAD, ST_HALT
  } state_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_INC, ALU_DEC, ALU_NOT
  } alu_op_e;

  typedef enum logic [4:0] {
    C_MOVE, C_STD, C_LDD, C_MVI, C_DEC, C_INC, C_NOT,
    C_JMP, C_JZ, C_JC, C_JRX, C_BAD, C_STI, C_LDI,
    C_ADD, C_SUB, C_AND, C_SWP
  } op_cls_e;

endpackage

// File: rtl/bcpu_decode.sv
module bcpu_decode
  import bcpu_pkg::*;
(
  input  logic [7:0]       op_i,
  output op_cls_e          cls_o,
  output alu_op_e          alu_o,
  output logic [SEL_W-1:0] dst_o,
  output logic [SEL_W-1:0] src_o,
  output logic [1:0]       pair_o
);

  always_comb begin
    cls_o  = C_BAD;
    alu_o  = ALU_ADD;
    dst_o  = op_i[2:0];
    src_o  = op_i[2:0];
    pair_o = op_i[1:0];
    unique case (op_i[7:6])
      2'b00: begin
        cls_o = C_MOVE;
        dst_o = op_i[5:3];
      end
      2'b01: begin
        unique case (op_i[5:3])
          3'b000: cls_o = C_STD;
          3'b001: cls_o = C_LDD;
          3'b010: cls_o = C_MVI;
          3'b011: begin cls_o = C_DEC; alu_o = ALU_DEC; end
          3'b100: begin cls_o = C_INC; alu_o = ALU_INC; end
          3'b101: begin cls_o = C_NOT; alu_o = ALU_NOT; end
          default: begin
            dst_o = '0;
            unique case (op_i[3:2])
              2'b00: begin
                unique case (op_i[1:0])
                  2'b00:   cls_o = C_JMP;
                  2'b01:   cls_o = C_JZ;
                  2'b10:   cls_o = C_JC;
                  default: cls_o = C_JRX;
                endcase
              end
              2'b01:   cls_o = C_BAD;
              2'b10:   cls_o = C_STI;
              default: cls_o = C_LDI;
            endcase
          end
        endcase
      end
      2'b10: begin
        dst_o = {1'b0, op_i[4:3]};
        if (op_i[5]) begin cls_o = C_SUB; alu_o = ALU_SUB; end
        else         begin cls_o = C_ADD; alu_o = ALU_ADD; end
      end
      default: begin
        dst_o = {1'b0, op_i[4:3]};
        if (op_i[5]) cls_o = C_SWP;
        else begin cls_o = C_AND; alu_o = ALU_AND; end
      end
    endcase
  end

endmodule

// File: rtl/bcpu_alu.sv
module bcpu_alu
  import bcpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              z_o,
  output logic              c_o,
  output logic              c_upd_o
);

  logic [DATA_W:0] ext_a, ext_b, wide;

  assign ext_a = {1'b0, a_i};
  assign ext_b = {1'b0, b_i};

  always_comb begin
    c_upd_o = 1'b1;
    unique case (op_i)
      ALU_ADD: wide = ext_a + ext_b;
      ALU_SUB: wide = ext_a - ext_b;
      ALU_INC: wide = ext_a + (DATA_W+1)'(1);
      ALU_DEC: wide = ext_a - (DATA_W+1)'(1);
      ALU_AND: begin wide = ext_a & ext_b; c_upd_o = 1'b0; end
      default: begin wide = {1'b0, ~a_i};  c_upd_o = 1'b0; end
    endcase
  end

  assign res_o = wide[DATA_W-1:0];
  assign c_o   = wide[DATA_W];
  assign z_o   = (res_o == '0);

endmodule

// File: rtl/bcpu_regfile.sv
module bcpu_regfile
  import bcpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wa_en_i,
  input  logic [SEL_W-1:0]                 wa_sel_i,
  input  logic [DATA_W-1:0]                wa_data_i,
  input  logic                             wb_en_i,
  input  logic [SEL_W-1:0]                 wb_sel_i,
  input  logic [DATA_W-1:0]                wb_data_i,
  output logic [REG_CNT-1:0][DATA_W-1:0]   regs_o
);

  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_o[g] <= '0;
      else if (wb_en_i && wb_sel_i == SEL_W'(g))
        regs_o[g] <= wb_data_i;
      else if (wa_en_i && wa_sel_i == SEL_W'(g))
        regs_o[g] <= wa_data_i;
    end
  end

  // R9: the array moves only when a write port is enabled
  a_r9_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wa_en_i || wb_en_i) |=> $stable(regs_o));

endmodule

// File: rtl/byte_cpu_core.sv
module byte_cpu_core
  import bcpu_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter logic [15:0] RESET_PC = 16'h0200
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [15:0]       mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              halt_o
);

  localparam int ADDR_W = 2 * DATA_W;

  state_e                          st_q, st_d;
  logic [ADDR_W-1:0]               pc_q, pc_d;
  logic [DATA_W-1:0]               ir_q, ir_d, lo_q, lo_d;
  logic                            zf_q, cf_q, flag_en;
  logic [REG_CNT-1:0][DATA_W-1:0]  rf;

  logic [DATA_W-1:0] op_cur;
  op_cls_e           cls;
  alu_op_e           alu_op;
  logic [SEL_W-1:0]  dst, src;
  logic [1:0]        pair;
  logic [SEL_W-1:0]  pair_lo, pair_hi;
  logic [ADDR_W-1:0] pair_addr, abs_addr;

  logic [DATA_W-1:0] alu_res;
  logic              alu_z, alu_c, alu_cupd;

  logic              wa_en, wb_en;
  logic [DATA_W-1:0] wa_data, wb_data;

  assign op_cur = (st_q == ST_DECODE) ? mem_rdata_i : ir_q;

  bcpu_decode u_dec (
    .op_i   (op_cur),
    .cls_o  (cls),
    .alu_o  (alu_op),
    .dst_o  (dst),
    .src_o  (src),
    .pair_o (pair)
  );

  bcpu_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i    (alu_op),
    .a_i     (rf[dst]),
    .b_i     (rf[src]),
    .res_o   (alu_res),
    .z_o     (alu_z),
    .c_o     (alu_c),
    .c_upd_o (alu_cupd)
  );

  bcpu_regfile #(.DATA_W(DATA_W)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wa_en_i   (wa_en),
    .wa_sel_i  (dst),
    .wa_data_i (wa_data),
    .wb_en_i   (wb_en),
    .wb_sel_i  (src),
    .wb_data_i (wb_data),
    .regs_o    (rf)
  );

  assign pair_lo   = {1'b0, pair};
  assign pair_hi   = pair_lo + SEL_W'(1);
  assign pair_addr = {rf[pair_hi], rf[pair_lo]};
  assign abs_addr  = {mem_rdata_i, lo_q};

  always_comb begin
    st_d        = st_q;
    pc_d        = pc_q;
    ir_d        = ir_q;
    lo_d        = lo_q;
    mem_addr_o  = pc_q;
    mem_we_o    = 1'b0;
    mem_wdata_o = rf[dst];
    wa_en       = 1'b0;
    wa_data     = alu_res;
    wb_en       = 1'b0;
    wb_data     = rf[dst];
    flag_en     = 1'b0;
    unique case (st_q)
      ST_FETCH: begin
        pc_d = pc_q + ADDR_W'(1);
        st_d = ST_DECODE;
      end
      ST_DECODE: begin
        ir_d = mem_rdata_i;
        st_d = ST_FETCH;
        unique case (cls)
          C_MOVE: begin wa_en = 1'b1; wa_data = rf[src]; end
          C_STD, C_LDD, C_JMP, C_JZ, C_JC: begin
            pc_d = pc_q + ADDR_W'(1);
            st_d = ST_OPLO;
          end
          C_MVI: begin
            pc_d = pc_q + ADDR_W'(1);
            st_d = ST_IMM;
          end
          C_DEC, C_INC, C_NOT, C_ADD, C_SUB, C_AND: begin
            wa_en   = 1'b1;
            flag_en = 1'b1;
          end
          C_JRX: pc_d = {rf[1], rf[0]};
          C_STI: begin
            mem_addr_o = pair_addr;
            mem_we_o   = 1'b1;
          end
          C_LDI: begin
            mem_addr_o = pair_addr;
            st_d       = ST_LOAD;
          end
          C_SWP: begin
            wa_en   = 1'b1;
            wa_data = rf[src];
            wb_en   = 1'b1;
          end
          default: st_d = ST_HALT;
        endcase
      end
      ST_OPLO: begin
        lo_d = mem_rdata_i;
        pc_d = pc_q + ADDR_W'(1);
        st_d = ST_OPHI;
      end
      ST_OPHI: begin
        st_d = ST_FETCH;
        unique case (cls)
          C_JMP: pc_d = abs_addr;
          C_JZ:  if (zf_q) pc_d = abs_addr;
          C_JC:  if (cf_q) pc_d = abs_addr;
          C_STD: begin
            mem_addr_o = abs_addr;
            mem_we_o   = 1'b1;
          end
          default: begin
            mem_addr_o = abs_addr;
            st_d       = ST_LOAD;
          end
        endcase
      end
      ST_IMM, ST_LOAD: begin
        wa_en   = 1'b1;
        wa_data = mem_rdata_i;
        st_d    = ST_FETCH;
      end
      default: st_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_FETCH;
      pc_q <= RESET_PC;
      ir_q <= '0;
      lo_q <= '0;
      zf_q <= 1'b0;
      cf_q <= 1'b0;
    end else begin
      st_q <= st_d;
      pc_q <= pc_d;
      ir_q <= ir_d;
      lo_q <= lo_d;
      if (flag_en) begin
        zf_q <= alu_z;
        if (alu_cupd) cf_q <= alu_c;
      end
    end
  end

  assign halt_o = (st_q == ST_HALT);

  // R11: halt persists and blocks writes
  a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |=> halt_o);
  a_r11_halt_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> !mem_we_o);
  // R10: flags can only move on the edge that leaves the decode state
  a_r10_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_DECODE) |=> ($stable(zf_q) && $stable(cf_q)));
  // R2: every fetch advances the program counter by one
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FETCH) |=> (pc_q == $past(pc_q) + ADDR_W'(1)));
  // R4, R5: writes come only from the decode or second-operand state
  a_r5_write_states: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (st_q == ST_DECODE || st_q == ST_OPHI));

endmodule

// File: tb/byte_cpu_core_tb_top.sv
module byte_cpu_core_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_we, halt;
  logic [7:0]  mem [0:4095];
  int          n_chk = 0, n_bad = 0, wp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_cpu_core dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_we_o    (mem_we),
    .mem_rdata_i (mem_rdata),
    .halt_o      (halt)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[11:0]];
  end

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic prep();
    for (int i = 0; i < 4096; i++) mem[i] = 8'h74;
    wp = 16'h0200;
  endtask

  task automatic emit(logic [7:0] b);
    mem[wp[11:0]] = b;
    wp++;
  endtask

  task automatic emit_a(logic [7:0] op, logic [15:0] a);
    emit(op); emit(a[7:0]); emit(a[15:8]);
  endtask

  // write 01h to dst if the jump condition holds, else 00h (uses R7)
  task automatic cap(logic [7:0] jop, logic [15:0] dst);
    int p = wp;
    emit(8'h57); emit(8'h01);
    emit_a(jop, 16'(p + 7));
    emit(8'h57); emit(8'h00);
    emit_a(8'h47, dst);
  endtask

  task automatic store_caps(logic [2:0] r, logic [15:0] base);
    emit_a({5'b01000, r}, base);
    cap(8'h71, base + 16'd1);
    cap(8'h72, base + 16'd2);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_prog(string req, int limit);
    int cyc = 0;
    do_reset();
    while (!halt && cyc < limit) begin @(negedge clk); cyc++; end
    check(req, "program ends in halt", {15'd0, halt}, 16'd1);
  endtask

  task automatic t_reset();
    prep();
    for (int i = 0; i < 16; i++) mem[12'h300 + i] = 8'hEE;
    for (int r = 0; r < 8; r++) emit_a(8'h40 | 8'(r), 16'(16'h0300 + r));
    cap(8'h71, 16'h0308);
    cap(8'h72, 16'h0309);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1", "halt in reset", {15'd0, halt}, 16'd0);
    check("R1", "first fetch address", mem_addr, 16'h0200);
    check("R1", "no write in reset", {15'd0, mem_we}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", "first operand address", mem_addr, 16'h0201);
    @(negedge clk);
    check("R2", "second operand address", mem_addr, 16'h0202);
    @(negedge clk);
    check("R2", "direct store write strobe", {15'd0, mem_we}, 16'd1);
    check("R2", "direct store address low byte first", mem_addr, 16'h0300);
    while (!halt) @(negedge clk);
    for (int r = 0; r < 8; r++)
      check("R1", "register cleared", {8'd0, mem[12'h300 + r]}, 16'h0000);
    check("R1", "Z clear after reset", {8'd0, mem[12'h308]}, 16'h0000);
    check("R1", "C clear after reset", {8'd0, mem[12'h309]}, 16'h0000);
  endtask

  task automatic t_copy();
    logic [7:0] src [6] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h00};
    prep();
    mem[12'h100] = 8'hFC; mem[12'h101] = 8'h03;
    mem[12'h102] = 8'hFE; mem[12'h103] = 8'h08;
    for (int i = 0; i < 6; i++) mem[12'h3FC + i] = src[i];
    for (int i = 0; i < 7; i++) mem[12'h8FE + i] = 8'hAA;
    emit_a(8'h49, 16'h0100); emit_a(8'h4A, 16'h0101);
    emit_a(8'h4B, 16'h0102); emit_a(8'h4C, 16'h0103);
    emit(8'h7D); emit(8'hC0); emit_a(8'h71, 16'h0225);           // 020C
    emit(8'h7B); emit(8'h61); emit_a(8'h72, 16'h021D);           // 0211
    emit(8'h63); emit_a(8'h72, 16'h0221); emit_a(8'h70, 16'h020C); // 0216
    emit(8'h62); emit_a(8'h70, 16'h0216);                        // 021D
    emit(8'h64); emit_a(8'h70, 16'h020C);                        // 0221
    emit(8'h74);                                                 // 0225
    run_prog("R4", 3000);
    for (int i = 0; i < 5; i++)
      check("R4", "copied byte across pointer carry", {8'd0, mem[12'h8FE + i]}, {8'd0, src[i]});
    check("R4", "terminating zero not copied", {8'd0, mem[12'h903]}, 16'h00AA);
    check("R3", "source left intact", {8'd0, mem[12'h3FF]}, 16'h0044);
  endtask

  task automatic t_alu();
    logic [7:0] exp [21] = '{8'h00, 8'h01, 8'h01,  8'hFE, 8'h00, 8'h01,
                             8'hFF, 8'h00, 8'h01,  8'h00, 8'h01, 8'h00,
                             8'h2C, 8'h00, 8'h01,  8'h0F, 8'h00, 8'h01,
                             8'h00, 8'h01, 8'h01};
    string tag [7] = '{"R7 INC", "R8 SUB", "R7 DEC0", "R7 DEC1", "R8 ADD", "R7 NOT", "R8 AND"};
    prep();
    emit(8'h51); emit(8'hFF); emit(8'h61); store_caps(3'd1, 16'h0300);
    emit(8'h52); emit(8'h05); emit(8'h53); emit(8'h07); emit(8'hB3); store_caps(3'd2, 16'h0303);
    emit(8'h51); emit(8'h00); emit(8'h59); store_caps(3'd1, 16'h0306);
    emit(8'h51); emit(8'h01); emit(8'h59); store_caps(3'd1, 16'h0309);
    emit(8'h51); emit(8'hC8); emit(8'h52); emit(8'h64); emit(8'h8A); store_caps(3'd1, 16'h030C);
    emit(8'h56); emit(8'hF0); emit(8'h6E); store_caps(3'd6, 16'h030F);
    emit(8'h52); emit(8'h0F); emit(8'h53); emit(8'hF0); emit(8'hD3); store_caps(3'd2, 16'h0312);
    emit(8'h74);
    run_prog("R7", 4000);
    for (int i = 0; i < 21; i++)
      check(tag[i/3], (i % 3 == 0) ? "result" : (i % 3 == 1) ? "Z" : "C",
            {8'd0, mem[12'h300 + i]}, {8'd0, exp[i]});
  endtask

  task automatic t_moves();
    prep();
    mem[12'h140] = 8'h00; mem[12'h141] = 8'h5C;
    emit(8'h50); emit(8'hFE); emit(8'h60);
    emit(8'h51); emit(8'h00); emit(8'h11); emit_a(8'h4C, 16'h0140);
    cap(8'h71, 16'h0320); cap(8'h72, 16'h0321);
    emit(8'h53); emit(8'hAB); emit(8'h55); emit(8'hCD); emit(8'hFD); emit(8'h33);
    emit_a(8'h4A, 16'h0141);
    emit_a(8'h43, 16'h0324); emit_a(8'h45, 16'h0325);
    emit_a(8'h46, 16'h0326); emit_a(8'h42, 16'h0327);
    emit(8'h51); emit(8'hFF); emit(8'h61);
    emit(8'hFD); emit(8'h33); emit(8'h51); emit(8'h07); emit_a(8'h4A, 16'h0141);
    cap(8'h71, 16'h0328); cap(8'h72, 16'h0329);
    emit(8'h74);
    run_prog("R9", 4000);
    check("R10", "zero move/load keeps Z clear", {8'd0, mem[12'h320]}, 16'h0000);
    check("R10", "zero move/load keeps C clear", {8'd0, mem[12'h321]}, 16'h0000);
    check("R9", "swap destination", {8'd0, mem[12'h324]}, 16'h00CD);
    check("R9", "swap source", {8'd0, mem[12'h325]}, 16'h00AB);
    check("R9", "copy after swap", {8'd0, mem[12'h326]}, 16'h00CD);
    check("R5", "direct load value", {8'd0, mem[12'h327]}, 16'h005C);
    check("R10", "nonzero moves keep Z set", {8'd0, mem[12'h328]}, 16'h0001);
    check("R10", "nonzero moves keep C set", {8'd0, mem[12'h329]}, 16'h0001);
  endtask

  task automatic t_jumps();
    int p;
    prep();
    mem[12'h333] = 8'h55; mem[12'h360] = 8'h3E; mem[12'h350] = 8'h00;
    emit(8'h50); emit(8'h10); emit(8'h51); emit(8'h02); emit(8'h73);
    emit(8'h57); emit(8'hBB); emit_a(8'h47, 16'h0330);
    wp = 16'h0210;
    emit(8'h57); emit(8'h11); emit_a(8'h47, 16'h0330);
    emit_a(8'h71, 16'h02F0); emit(8'h57); emit(8'h22); emit_a(8'h47, 16'h0331);
    emit_a(8'h72, 16'h02F0); emit(8'h57); emit(8'h33); emit_a(8'h47, 16'h0332);
    p = wp;
    emit_a(8'h70, 16'(p + 8)); emit(8'h57); emit(8'hEE); emit_a(8'h47, 16'h0333);
    emit(8'h53); emit(8'h50); emit(8'h54); emit(8'h03); emit(8'h50); emit(8'h9C); emit(8'h7B);
    emit(8'h51); emit(8'h60); emit(8'h52); emit(8'h03); emit(8'h7D);
    emit_a(8'h40, 16'h0334);
    emit(8'h74);
    run_prog("R3", 2000);
    check("R3", "jump through R1:R0", {8'd0, mem[12'h330]}, 16'h0011);
    check("R3", "Z jump not taken when clear", {8'd0, mem[12'h331]}, 16'h0022);
    check("R3", "C jump not taken when clear", {8'd0, mem[12'h332]}, 16'h0033);
    check("R3", "absolute jump skips code", {8'd0, mem[12'h333]}, 16'h0055);
    check("R4", "indirect store via pair 3", {8'd0, mem[12'h350]}, 16'h009C);
    check("R4", "indirect load via pair 1", {8'd0, mem[12'h334]}, 16'h003E);
  endtask

  task automatic t_halt();
    int writes = 0;
    prep();
    mem[12'h341] = 8'h99;
    emit(8'h51); emit(8'h42); emit_a(8'h41, 16'h0340);
    emit(8'h75); emit_a(8'h41, 16'h0341);
    run_prog("R11", 500);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_we) writes++;
      if (!halt) writes += 100;
    end
    check("R11", "halt held without writes", 16'(writes), 16'd0);
    check("R6", "immediate stored before halt", {8'd0, mem[12'h340]}, 16'h0042);
    check("R11", "code after undefined opcode skipped", {8'd0, mem[12'h341]}, 16'h0099);
    for (int op = 8'h74; op <= 8'h77; op++) begin
      prep();
      mem[12'h200] = 8'(op);
      do_reset();
      @(negedge clk);
      check("R11", "no halt one edge after fetch", {15'd0, halt}, 16'd0);
      @(negedge clk);
      check("R11", "halt two edges after fetch", {15'd0, halt}, 16'd1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_copy();
    t_alu();
    t_moves();
    t_jumps();
    t_halt();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule